// File: doc/BRIEF.md
# Banked CPU Register File

This block is the register storage of a small CPU core. It holds four 16-bit data registers (D0..D3), two 24-bit address registers (X0, X1) and a 24-bit frame pointer (FP). All of these exist twice, once in each of two banks. It also holds a set of registers that both banks share: a 24-bit static base (SBASE), a 24-bit user stack pointer (USTK), a 24-bit interrupt stack pointer (ISTK), a 24-bit vector table base (VBASE), a 24-bit program counter (PC) and a 16-bit status word (STAT).

The file has one combinational read port and one synchronous write port. Each port selects a register by a 4-bit code and an access size: byte, word (16 bits), address (24 bits) or pair (32 bits). On the two lower data registers the byte size reaches the high or low half. The pair size reaches a 32-bit concatenation of two data registers. A stack alias code reaches USTK or ISTK. Two bits of STAT select the active bank and the stack behind the alias. A combination of code and size that is not supported raises an error flag and has no effect.

The bank and stack selection is held in a four-state context machine. Its states are CTX_B0_ISP, CTX_B0_USP, CTX_B1_ISP and CTX_B1_USP. Reset enters CTX_B0_ISP. Every accepted STAT write is a transition to the state named by the written bank bit (bit 4) and stack bit (bit 7). Any other cycle is a hold transition.

Top module: `rf_banked`

## Requirements
- R1: After an active-low reset, every register reads as zero, bank 0 is active (`bank_sel`=0) and the alias reaches ISTK (`usp_sel`=0).
- R2: Word size (code 1) on codes 0..3 writes and reads D0..D3 of the active bank. Word size on code 13 writes and reads STAT.
- R3: Byte size (code 0) is legal only on codes 0 and 1. `hi`=1 reaches bits 15:8 and `hi`=0 reaches bits 7:0. A byte write takes `wr_data[7:0]` and leaves the other half unchanged.
- R4: Pair size (code 3) is legal on codes 0 and 1. Code 0 reaches {D2,D0} and code 1 reaches {D3,D1}, with the higher-numbered register in bits 31:16.
- R5: Address size (code 2) reaches these codes: 4 X0, 5 X1, 6 SBASE, 7 FP, 9 USTK, 10 ISTK, 11 VBASE, 12 PC. A write stores `wr_data[23:0]`.
- R6: STAT bit 4 selects the bank. D0..D3, X0, X1 and FP are banked; the other registers are shared. The contents of the bank that is not selected are kept.
- R7: Code 8 at address size reaches USTK when STAT bit 7 is 1 and ISTK when it is 0.
- R8: STAT bit 1 always reads 0. The other STAT bits (carry 0, zero 2, sign 3, bank 4, overflow 5, stack 7 and the rest) read back as written.
- R9: A read in the same cycle as a write returns the value from before the write. A read in the same cycle as a STAT write uses the bank and stack selection from before the write.
- R10: Every other code and size combination, and codes 14 and 15 in any size, raises `wr_err` or `rd_err`. Such a write changes no register.
- R11: Read data is zero-extended to 32 bits. An illegal read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_code | input | 4 | Read register code |
| rd_size | input | 2 | Read size: 0 byte, 1 word, 2 address, 3 pair |
| rd_hi | input | 1 | Read the high byte for byte size |
| rd_data | output | 32 | Read data, zero-extended |
| rd_err | output | 1 | Read combination not supported |
| wr_en | input | 1 | Write request |
| wr_code | input | 4 | Write register code |
| wr_size | input | 2 | Write size |
| wr_hi | input | 1 | Write the high byte for byte size |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Write combination not supported |
| bank_sel | output | 1 | Active bank |
| usp_sel | output | 1 | Stack alias reaches USTK |

## Verification
The assertions take for granted that the inputs have known values once reset is released, and that the inputs change only away from the rising clock edge. Under those conditions, a sampled STAT write fully determines the next context state, and a rejected write fully determines that the register contents do not change. The stimulus drives every input on the falling edge and assigns each one a defined value before reset is released. It then walks all 128 combinations of code, size and half select under six status-word values, which together cover every context state.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
    parameter int DATA_W   = 16;
    parameter int ADDR_W   = 24;
    parameter int NUM_DREG = 4;
    parameter int NUM_AREG = 2;
    parameter int NUM_BANK = 2;
    parameter int CODE_W   = 4;
    localparam int BYTE_W  = DATA_W / 2;
    localparam int WIDE_W  = 2 * DATA_W;

    // status word bit positions
    localparam int ST_CARRY = 0;
    localparam int ST_DBG   = 1;
    localparam int ST_ZERO  = 2;
    localparam int ST_SIGN  = 3;
    localparam int ST_BANK  = 4;
    localparam int ST_OVF   = 5;
    localparam int ST_STACK = 7;

    typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_ADDR, SZ_PAIR} size_t;

    typedef enum logic [CODE_W-1:0] {
        RC_D0, RC_D1, RC_D2, RC_D3, RC_X0, RC_X1, RC_SBASE, RC_FP,
        RC_STK, RC_USTK, RC_ISTK, RC_VBASE, RC_PC, RC_STAT, RC_RSV0, RC_RSV1
    } code_t;

    typedef enum logic [3:0] {
        T_D0, T_D1, T_D2, T_D3, T_X0, T_X1, T_FP, T_SBASE,
        T_USTK, T_ISTK, T_VBASE, T_PC, T_STAT, T_NONE
    } tgt_t;

    typedef enum logic [2:0] {K_LO, K_HI, K_WORD, K_ADDR, K_PAIR} kind_t;

    typedef struct packed {
        logic  ok;
        tgt_t  tgt;
        kind_t kind;
    } acc_t;

    typedef enum logic [1:0] {
        CTX_B0_ISP = 2'b00,
        CTX_B0_USP = 2'b01,
        CTX_B1_ISP = 2'b10,
        CTX_B1_USP = 2'b11
    } ctx_t;
endpackage

// File: rtl/rf_decode.sv
`timescale 1ns/1ps
module rf_decode
    import rf_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        size,
    input  logic              hi,
    input  logic              usp_sel,
    output acc_t              acc
);
    code_t c;
    size_t s;

    assign c = code_t'(code);
    assign s = size_t'(size);

    always_comb begin
        acc = '{ok: 1'b0, tgt: T_NONE, kind: K_WORD};
        unique case (s)
            SZ_BYTE: begin
                acc.kind = hi ? K_HI : K_LO;
                if (c == RC_D0) begin acc.ok = 1'b1; acc.tgt = T_D0; end
                else if (c == RC_D1) begin acc.ok = 1'b1; acc.tgt = T_D1; end
            end
            SZ_WORD: begin
                acc.kind = K_WORD;
                case (c)
                    RC_D0:   begin acc.ok = 1'b1; acc.tgt = T_D0;   end
                    RC_D1:   begin acc.ok = 1'b1; acc.tgt = T_D1;   end
                    RC_D2:   begin acc.ok = 1'b1; acc.tgt = T_D2;   end
                    RC_D3:   begin acc.ok = 1'b1; acc.tgt = T_D3;   end
                    RC_STAT: begin acc.ok = 1'b1; acc.tgt = T_STAT; end
                    default: ;
                endcase
            end
            SZ_ADDR: begin
                acc.kind = K_ADDR;
                case (c)
                    RC_X0:    begin acc.ok = 1'b1; acc.tgt = T_X0;    end
                    RC_X1:    begin acc.ok = 1'b1; acc.tgt = T_X1;    end
                    RC_SBASE: begin acc.ok = 1'b1; acc.tgt = T_SBASE; end
                    RC_FP:    begin acc.ok = 1'b1; acc.tgt = T_FP;    end
                    RC_STK:   begin acc.ok = 1'b1; acc.tgt = usp_sel ? T_USTK : T_ISTK; end
                    RC_USTK:  begin acc.ok = 1'b1; acc.tgt = T_USTK;  end
                    RC_ISTK:  begin acc.ok = 1'b1; acc.tgt = T_ISTK;  end
                    RC_VBASE: begin acc.ok = 1'b1; acc.tgt = T_VBASE; end
                    RC_PC:    begin acc.ok = 1'b1; acc.tgt = T_PC;    end
                    default: ;
                endcase
            end
            SZ_PAIR: begin
                acc.kind = K_PAIR;
                if (c == RC_D0) begin acc.ok = 1'b1; acc.tgt = T_D0; end
                else if (c == RC_D1) begin acc.ok = 1'b1; acc.tgt = T_D1; end
            end
            default: ;
        endcase
    end

    // R4: a pair access is always anchored on one of the two lower data registers
    always_comb begin
        assert_pair_base_R4: assert (!(acc.ok && acc.kind == K_PAIR) ||
                                     acc.tgt == T_D0 || acc.tgt == T_D1);
    end
endmodule

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank
    import rf_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  acc_t                                 acc,
    input  logic [WIDE_W-1:0]                    wdata,
    output logic [NUM_DREG-1:0][DATA_W-1:0]      dreg,
    output logic [NUM_AREG-1:0][ADDR_W-1:0]      areg,
    output logic [ADDR_W-1:0]                    fp
);
    localparam int HALF = NUM_DREG / 2;

    for (genvar i = 0; i < NUM_DREG; i++) begin : g_dreg
        localparam int  BASE  = i % HALF;
        localparam bit  UPPER = (i >= HALF);
        logic own, base_hit, pair_lo, pair_hi;

        assign own      = (acc.tgt == tgt_t'(4'(i)));
        assign base_hit = (acc.tgt == tgt_t'(4'(BASE)));
        assign pair_lo  = !UPPER && own && acc.kind == K_PAIR;
        assign pair_hi  = UPPER && base_hit && acc.kind == K_PAIR;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dreg[i] <= '0;
            end else if (we) begin
                if ((own && acc.kind == K_WORD) || pair_lo)
                    dreg[i] <= wdata[DATA_W-1:0];
                else if (pair_hi)
                    dreg[i] <= wdata[WIDE_W-1:DATA_W];
                else if (own && acc.kind == K_LO)
                    dreg[i][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
                else if (own && acc.kind == K_HI)
                    dreg[i][DATA_W-1:BYTE_W] <= wdata[BYTE_W-1:0];
            end
        end
    end

    for (genvar j = 0; j < NUM_AREG; j++) begin : g_areg
        logic hit;
        assign hit = (acc.tgt == tgt_t'(4'(int'(T_X0) + j))) && acc.kind == K_ADDR;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                areg[j] <= '0;
            else if (we && hit)
                areg[j] <= wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fp <= '0;
        else if (we && acc.tgt == T_FP && acc.kind == K_ADDR)
            fp <= wdata[ADDR_W-1:0];
    end
endmodule

// File: rtl/rf_shared.sv
`timescale 1ns/1ps
module rf_shared
    import rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  acc_t               acc,
    input  logic [WIDE_W-1:0]  wdata,
    output logic [ADDR_W-1:0]  sbase,
    output logic [ADDR_W-1:0]  ustk,
    output logic [ADDR_W-1:0]  istk,
    output logic [ADDR_W-1:0]  vbase,
    output logic [ADDR_W-1:0]  pc,
    output logic [DATA_W-1:0]  stat,
    output logic               bank_sel,
    output logic               usp_sel
);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << ST_BANK) | (DATA_W'(1) << ST_STACK) | (DATA_W'(1) << ST_DBG);

    ctx_t ctx_q, ctx_d;
    logic [DATA_W-1:0] stat_q;
    logic stat_wr;

    assign stat_wr = we && acc.tgt == T_STAT;

    // context state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= CTX_B0_ISP;
        else        ctx_q <= ctx_d;
    end

    // next-state: a status write jumps to the context its bits name
    always_comb begin
        ctx_d = ctx_q;
        if (stat_wr) begin
            unique case ({wdata[ST_BANK], wdata[ST_STACK]})
                2'b00: ctx_d = CTX_B0_ISP;
                2'b01: ctx_d = CTX_B0_USP;
                2'b10: ctx_d = CTX_B1_ISP;
                2'b11: ctx_d = CTX_B1_USP;
                default: ctx_d = ctx_q;
            endcase
        end
    end

    // outputs of the context machine
    always_comb begin
        unique case (ctx_q)
            CTX_B0_ISP: begin bank_sel = 1'b0; usp_sel = 1'b0; end
            CTX_B0_USP: begin bank_sel = 1'b0; usp_sel = 1'b1; end
            CTX_B1_ISP: begin bank_sel = 1'b1; usp_sel = 1'b0; end
            CTX_B1_USP: begin bank_sel = 1'b1; usp_sel = 1'b1; end
            default:    begin bank_sel = 1'b0; usp_sel = 1'b0; end
        endcase
    end

    always_comb begin
        stat = stat_q & ~CTRL_MASK;
        stat[ST_BANK]  = bank_sel;
        stat[ST_STACK] = usp_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            sbase  <= '0;
            ustk   <= '0;
            istk   <= '0;
            vbase  <= '0;
            pc     <= '0;
        end else if (we) begin
            unique case (acc.tgt)
                T_STAT:  stat_q <= wdata[DATA_W-1:0];
                T_SBASE: sbase  <= wdata[ADDR_W-1:0];
                T_USTK:  ustk   <= wdata[ADDR_W-1:0];
                T_ISTK:  istk   <= wdata[ADDR_W-1:0];
                T_VBASE: vbase  <= wdata[ADDR_W-1:0];
                T_PC:    pc     <= wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // R6, R7: the context follows the status bits written one cycle earlier
    assert_ctx_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (bank_sel == $past(wdata[ST_BANK]) && usp_sel == $past(wdata[ST_STACK])));

    // R8: the reserved status bit never reads back as set after a write
    assert_dbg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> !stat[ST_DBG]);
endmodule

// File: rtl/rf_banked.sv
`timescale 1ns/1ps
module rf_banked
    import rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_code,
    input  logic [1:0]        rd_size,
    input  logic              rd_hi,
    output logic [31:0]       rd_data,
    output logic              rd_err,
    input  logic              wr_en,
    input  logic [3:0]        wr_code,
    input  logic [1:0]        wr_size,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    output logic              wr_err,
    output logic              bank_sel,
    output logic              usp_sel
);
    acc_t rd_acc, wr_acc;
    logic wr_go;

    logic [NUM_BANK-1:0][NUM_DREG-1:0][DATA_W-1:0] bk_d;
    logic [NUM_BANK-1:0][NUM_AREG-1:0][ADDR_W-1:0] bk_a;
    logic [NUM_BANK-1:0][ADDR_W-1:0]               bk_fp;
    logic [ADDR_W-1:0] sbase, ustk, istk, vbase, pc;
    logic [DATA_W-1:0] stat;

    rf_decode u_rd_dec (.code(rd_code), .size(rd_size), .hi(rd_hi),
                        .usp_sel(usp_sel), .acc(rd_acc));
    rf_decode u_wr_dec (.code(wr_code), .size(wr_size), .hi(wr_hi),
                        .usp_sel(usp_sel), .acc(wr_acc));

    assign wr_go  = wr_en && wr_acc.ok;
    assign wr_err = wr_en && !wr_acc.ok;
    assign rd_err = !rd_acc.ok;

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_go && (32'(bank_sel) == b);
        rf_bank u_bank (.clk(clk), .rst_n(rst_n), .we(bank_we), .acc(wr_acc),
                        .wdata(wr_data), .dreg(bk_d[b]), .areg(bk_a[b]), .fp(bk_fp[b]));
    end

    rf_shared u_shared (.clk(clk), .rst_n(rst_n), .we(wr_go), .acc(wr_acc),
                        .wdata(wr_data), .sbase(sbase), .ustk(ustk), .istk(istk),
                        .vbase(vbase), .pc(pc), .stat(stat),
                        .bank_sel(bank_sel), .usp_sel(usp_sel));

    logic [NUM_DREG-1:0][DATA_W-1:0] cur_d;
    logic [NUM_AREG-1:0][ADDR_W-1:0] cur_a;
    logic [1:0] idx;

    assign cur_d = bk_d[bank_sel];
    assign cur_a = bk_a[bank_sel];
    assign idx   = rd_acc.tgt[1:0];

    always_comb begin
        rd_data = '0;
        if (rd_acc.ok) begin
            unique case (rd_acc.kind)
                K_LO:   rd_data = 32'(cur_d[idx][BYTE_W-1:0]);
                K_HI:   rd_data = 32'(cur_d[idx][DATA_W-1:BYTE_W]);
                K_WORD: rd_data = (rd_acc.tgt == T_STAT) ? 32'(stat) : 32'(cur_d[idx]);
                K_PAIR: rd_data = {cur_d[{1'b1, idx[0]}], cur_d[{1'b0, idx[0]}]};
                K_ADDR: begin
                    case (rd_acc.tgt)
                        T_X0:    rd_data = 32'(cur_a[0]);
                        T_X1:    rd_data = 32'(cur_a[1]);
                        T_FP:    rd_data = 32'(bk_fp[bank_sel]);
                        T_SBASE: rd_data = 32'(sbase);
                        T_USTK:  rd_data = 32'(ustk);
                        T_ISTK:  rd_data = 32'(istk);
                        T_VBASE: rd_data = 32'(vbase);
                        T_PC:    rd_data = 32'(pc);
                        default: rd_data = '0;
                    endcase
                end
                default: rd_data = '0;
            endcase
        end
    end

    logic [$bits(bk_d)+$bits(bk_a)+$bits(bk_fp)+5*ADDR_W+DATA_W-1:0] snap;
    assign snap = {bk_d, bk_a, bk_fp, sbase, ustk, istk, vbase, pc, stat};

    // R10: a rejected write leaves every register as it was
    assert_reject_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(snap));

    // R11: a rejected read drives zero data
    assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_data == 32'd0);

    // R7: the stack alias returns the stack chosen by the current context
    assert_stack_alias_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code == 4'd8 && rd_size == 2'd2) |-> rd_data == 32'(usp_sel ? ustk : istk));
endmodule

// File: tb/test_rf_banked.sv
`timescale 1ns/1ps
module test_rf_banked;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_code = '0;
    logic [1:0]  rd_size = '0;
    logic        rd_hi = 1'b0;
    logic [31:0] rd_data;
    logic        rd_err;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_code = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic        bank_sel;
    logic        usp_sel;

    always #10 clk = ~clk;

    rf_banked i_rf_banked (
        .clk(clk), .rst_n(rst_n),
        .rd_code(rd_code), .rd_size(rd_size), .rd_hi(rd_hi),
        .rd_data(rd_data), .rd_err(rd_err),
        .wr_en(wr_en), .wr_code(wr_code), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_err(wr_err),
        .bank_sel(bank_sel), .usp_sel(usp_sel)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [15:0] m_d   [2][4];
    logic [23:0] m_x   [2][2];
    logic [23:0] m_fp  [2];
    logic [23:0] m_sbase, m_ustk, m_istk, m_vbase, m_pc;
    logic [15:0] m_stat;

    function automatic bit legal(int c, int s);
        case (s)
            0: return c < 2;
            1: return c < 4 || c == 13;
            2: return c >= 4 && c <= 12;
            default: return c < 2;
        endcase
    endfunction

    function automatic logic [31:0] expect_rd(int c, int s, bit h);
        int b = int'(m_stat[4]);
        if (!legal(c, s)) return 32'd0;
        case (s)
            0: return h ? 32'(m_d[b][c][15:8]) : 32'(m_d[b][c][7:0]);
            1: return (c == 13) ? 32'(m_stat) : 32'(m_d[b][c]);
            3: return {m_d[b][c+2], m_d[b][c]};
            default: begin
                case (c)
                    4: return 32'(m_x[b][0]);
                    5: return 32'(m_x[b][1]);
                    6: return 32'(m_sbase);
                    7: return 32'(m_fp[b]);
                    8: return 32'(m_stat[7] ? m_ustk : m_istk);
                    9: return 32'(m_ustk);
                    10: return 32'(m_istk);
                    11: return 32'(m_vbase);
                    default: return 32'(m_pc);
                endcase
            end
        endcase
    endfunction

    function automatic void model_write(int c, int s, bit h, logic [31:0] d);
        int b = int'(m_stat[4]);
        if (!legal(c, s)) return;
        case (s)
            0: if (h) m_d[b][c][15:8] = d[7:0]; else m_d[b][c][7:0] = d[7:0];
            1: if (c == 13) m_stat = d[15:0] & 16'hFFFD; else m_d[b][c] = d[15:0];
            3: begin m_d[b][c] = d[15:0]; m_d[b][c+2] = d[31:16]; end
            default: begin
                case (c)
                    4: m_x[b][0] = d[23:0];
                    5: m_x[b][1] = d[23:0];
                    6: m_sbase = d[23:0];
                    7: m_fp[b] = d[23:0];
                    8: if (m_stat[7]) m_ustk = d[23:0]; else m_istk = d[23:0];
                    9: m_ustk = d[23:0];
                    10: m_istk = d[23:0];
                    11: m_vbase = d[23:0];
                    default: m_pc = d[23:0];
                endcase
            end
        endcase
    endfunction

    function automatic string tag_of(int c, int s);
        if (!legal(c, s)) return "R11";
        case (s)
            0: return "R3";
            1: return (c == 13) ? "R8" : "R2";
            2: return (c == 8) ? "R7" : "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sweep_reads();
        for (int c = 0; c < 16; c++)
            for (int s = 0; s < 4; s++)
                for (int h = 0; h < 2; h++) begin
                    rd_code = 4'(c); rd_size = 2'(s); rd_hi = 1'(h);
                    #1;
                    chk("R10", 32'(rd_err), 32'(!legal(c, s)));
                    chk(tag_of(c, s), rd_data, expect_rd(c, s, 1'(h)));
                end
    endtask

    task automatic wr(int c, int s, bit h, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_code = 4'(c); wr_size = 2'(s); wr_hi = h; wr_data = d;
        #1;
        chk("R10", 32'(wr_err), 32'(!legal(c, s)));
        @(posedge clk);
        #1;
        model_write(c, s, h, d);
        wr_en = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] stat_vals [6];
        stat_vals[0] = 16'h0000; stat_vals[1] = 16'h0010; stat_vals[2] = 16'h0080;
        stat_vals[3] = 16'h0090; stat_vals[4] = 16'hFFFF; stat_vals[5] = 16'h002D;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 4; i++) m_d[b][i] = '0;
            m_x[b][0] = '0; m_x[b][1] = '0; m_fp[b] = '0;
        end
        m_sbase = '0; m_ustk = '0; m_istk = '0; m_vbase = '0; m_pc = '0; m_stat = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", 32'(bank_sel), 32'd0);
        chk("R1", 32'(usp_sel), 32'd0);
        for (int c = 0; c < 16; c++)
            for (int s = 0; s < 4; s++) begin
                rd_code = 4'(c); rd_size = 2'(s); rd_hi = 1'b0;
                #1;
                if (legal(c, s)) chk("R1", rd_data, 32'd0);
            end

        for (int r = 0; r < 6; r++) begin
            wr(13, 1, 1'b0, 32'hABCD_0000 | 32'(stat_vals[r]));
            chk("R6", 32'(bank_sel), 32'(stat_vals[r][4]));
            chk("R7", 32'(usp_sel), 32'(stat_vals[r][7]));
            rd_code = 4'd13; rd_size = 2'd1; rd_hi = 1'b0;
            #1;
            chk("R8", rd_data, 32'(stat_vals[r] & 16'hFFFD));
            // R6: the other bank and shared registers keep their contents
            sweep_reads();
            // write order: word, pair, address, byte
            for (int si = 0; si < 4; si++) begin
                int s;
                s = (si == 0) ? 1 : (si == 1) ? 3 : (si == 2) ? 2 : 0;
                for (int c = 0; c < 16; c++)
                    for (int h = 0; h < 2; h++) begin
                        if (!(c == 13 && s == 1))
                            wr(c, s, 1'(h), 32'h1357_9BDF ^ (32'(r * 131 + c * 17 + s * 5 + h) * 32'h0101_0F3B));
                    end
            end
            sweep_reads();
        end

        // R9: same-cycle read while the status word flips bank and stack
        @(negedge clk);
        wr_en = 1'b1; wr_code = 4'd13; wr_size = 2'd1; wr_hi = 1'b0; wr_data = 32'h0000_0090;
        rd_code = 4'd0; rd_size = 2'd1; rd_hi = 1'b0;
        #1;
        chk("R9", rd_data, 32'(m_d[0][0]));
        rd_code = 4'd8; rd_size = 2'd2;
        #1;
        chk("R9", rd_data, 32'(m_istk));
        rd_code = 4'd13; rd_size = 2'd1;
        #1;
        chk("R9", rd_data, 32'(m_stat));
        @(posedge clk);
        #1;
        model_write(13, 1, 1'b0, 32'h0000_0090);
        wr_en = 1'b0;
        rd_code = 4'd0; rd_size = 2'd1;
        #1;
        chk("R6", rd_data, 32'(m_d[1][0]));
        rd_code = 4'd8; rd_size = 2'd2;
        #1;
        chk("R7", rd_data, 32'(m_ustk));

        // R9: data write and read of the same register in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_code = 4'd2; wr_size = 2'd1; wr_data = 32'h0000_5A5A;
        rd_code = 4'd2; rd_size = 2'd1;
        #1;
        chk("R9", rd_data, 32'(m_d[1][2]));
        @(posedge clk);
        #1;
        model_write(2, 1, 1'b0, 32'h0000_5A5A);
        wr_en = 1'b0;
        #1;
        chk("R2", rd_data, 32'h0000_5A5A);

        sweep_reads();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule